// File: doc/BRIEF.md
# SPI Pin Router with Single-Wire Data Mode

This block sits between an SPI shift engine and the four SPI port pads: master-in/slave-out data (pin 0), master-out/slave-in data (pin 1), serial clock (pin 2) and slave select (pin 3). It decides which pad carries which serial signal and which pads may drive. It also decides which pad the received bit is taken from. Two inputs select the routing. The first is a single-wire bit held in the block's own control register. The second is the master/slave bit, which comes from the engine's configuration. In single-wire mode one data pad carries data in both directions, and the other data pad is handed back to general-purpose port use.

Each output driver is gated by a per-pad direction bit. Depending on the pad, the gate also uses the master state, the slave-select level or the select-output enable. The control register also holds a stop-in-wait bit. While that bit is set and the system reports wait mode, the block withdraws the run enable of the serial clock generator.

Every output of the block is registered. Pad values, pad enables and the signals returned to the engine all follow their inputs by one clock cycle.

Top module: `spio_pin_ctrl`

## Requirements
- R1: After synchronous reset the control register reads 0x00, every pad output enable is 0, and `clk_run` is 1.
- R2: A write stores data bit 0 as the single-wire bit and data bit 1 as the stop-in-wait bit. Writes are accepted at any time. Reads return those two bits in positions 0 and 1, with bits 7:2 always reading 0.
- R3: With single-wire=0 and slave: pad 0 carries `core_sdo`, the received bit comes from pad 1, and pads 1 to 3 never drive.
- R4: With single-wire=0 and master: pad 1 carries `core_sdo`, pad 2 carries `core_sck_out`, the received bit comes from pad 0, and pad 0 never drives.
- R5: With single-wire=1 and slave: pad 0 is the shared data pad. It carries `core_sdo` and is also the source of the received bit. Pad 1 becomes general-purpose.
- R6: With single-wire=1 and master: pad 1 is the shared data pad. It carries `core_sdo` and is also the source of the received bit. Pad 0 becomes general-purpose.
- R7: The slave data driver is enabled only when its direction bit is 1, the select pad (pad 3) is low, and `mstr` is 0.
- R8: The master data driver and the clock driver are enabled only when the pad's direction bit is 1 and `mstr` is 1. A pad whose direction bit is 0 never drives.
- R9: Pad 3 drives `core_ss_out` only when `ddr[3]`, `ssoe` and `mstr` are all 1. In every other case it stays an input.
- R10: A data pad released to general-purpose use outputs `port_out` for that pad, with its enable equal to that pad's direction bit. The SPI signals have no effect on it.
- R11: When stop-in-wait is 1 and `wait_mode` is 1, `clk_run` is 0. In every other case `clk_run` is 1.
- R12: All outputs change exactly one clock edge after their inputs. A pad in an SPI input role outputs the value 0. `core_sck_in` and `core_ss_in` mirror pads 2 and 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Control register write strobe |
| reg_wdata | input | 8 | Control register write data |
| reg_rdata | output | 8 | Control register read data |
| mstr | input | 1 | 1 = master, 0 = slave |
| ssoe | input | 1 | Select output enable |
| ddr | input | 4 | Per-pad direction bits (1 = output allowed) |
| port_out | input | 4 | General-purpose port output values |
| wait_mode | input | 1 | System wait-mode indication |
| core_sdo | input | 1 | Serial data from the shift engine |
| core_sck_out | input | 1 | Serial clock from the baud generator |
| core_ss_out | input | 1 | Select value from the engine |
| pad_in | input | 4 | Pad input levels |
| pad_out | output | 4 | Pad output values |
| pad_oe | output | 4 | Pad output enables |
| core_sdi | output | 1 | Received serial bit to the engine |
| core_sck_in | output | 1 | Pad clock level to the engine |
| core_ss_in | output | 1 | Pad select level to the engine |
| clk_run | output | 1 | Run enable of the serial clock generator |

## Verification
The bench aims at the four routing combinations. A mux that swapped the shared pad between master and slave would sample the received bit from the general-purpose pad and would drive the wrong pin. It raises the select pad while in slave mode. A slave driver that ignored the select would then fight another slave on the data line. It also walks the select-output gating with `ssoe` low, where a loose gate would drive the select line against an external master. It checks the wait-mode clock stop in every stop/wait combination, the register's unused bits, and the one-cycle output latency, which a mux with no output register would break.

// File: rtl/spio_pkg.sv
package spio_pkg;
  localparam int PIN_N    = 4;
  localparam int PIN_MISO = 0;
  localparam int PIN_MOSI = 1;
  localparam int PIN_SCK  = 2;
  localparam int PIN_SS   = 3;
  localparam int PIN_W    = $clog2(PIN_N);

  typedef struct packed {
    logic stop_wait;
    logic one_wire;
  } ctl_t;

  typedef enum logic [1:0] {
    FN_SPI_IN  = 2'd0,
    FN_SPI_OUT = 2'd1,
    FN_SPI_IO  = 2'd2,
    FN_GPIO    = 2'd3
  } pin_fn_e;
endpackage

// File: rtl/spio_ctl_reg.sv
module spio_ctl_reg
  import spio_pkg::*;
#(
  parameter int REG_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  logic [REG_W-1:0] wdata,
  output ctl_t             ctl,
  output logic [REG_W-1:0] rdata
);
  localparam int CTL_W = $bits(ctl_t);

  always_ff @(posedge clk) begin
    if (rst)     ctl <= '0;
    else if (wr) ctl <= ctl_t'(wdata[CTL_W-1:0]);
  end

  always_comb begin
    rdata = '0;
    rdata[CTL_W-1:0] = ctl;
  end

  AST_CTL_WRITE: assert property (@(posedge clk) disable iff (rst)
    wr |=> (ctl == ctl_t'($past(wdata[CTL_W-1:0])))); // R2
endmodule

// File: rtl/spio_role_dec.sv
module spio_role_dec
  import spio_pkg::*;
(
  input  logic                  one_wire,
  input  logic                  mstr,
  input  logic                  ssoe,
  input  logic                  ss_pad,
  output pin_fn_e [PIN_N-1:0]   fn,
  output logic    [PIN_N-1:0]   gate,
  output logic    [PIN_W-1:0]   sdi_sel
);
  always_comb begin
    fn      = {PIN_N{FN_SPI_IN}};
    gate    = '0;
    sdi_sel = PIN_W'(PIN_MISO);
    unique case ({one_wire, mstr})
      2'b00: begin
        fn[PIN_MISO]   = FN_SPI_OUT;
        gate[PIN_MISO] = ~ss_pad;
        sdi_sel        = PIN_W'(PIN_MOSI);
      end
      2'b01: begin
        fn[PIN_MOSI]   = FN_SPI_OUT;
        gate[PIN_MOSI] = 1'b1;
        sdi_sel        = PIN_W'(PIN_MISO);
      end
      2'b10: begin
        fn[PIN_MISO]   = FN_SPI_IO;
        gate[PIN_MISO] = ~ss_pad;
        fn[PIN_MOSI]   = FN_GPIO;
        sdi_sel        = PIN_W'(PIN_MISO);
      end
      default: begin
        fn[PIN_MOSI]   = FN_SPI_IO;
        gate[PIN_MOSI] = 1'b1;
        fn[PIN_MISO]   = FN_GPIO;
        sdi_sel        = PIN_W'(PIN_MOSI);
      end
    endcase
    if (mstr) begin
      fn[PIN_SCK]   = FN_SPI_OUT;
      gate[PIN_SCK] = 1'b1;
      if (ssoe) begin
        fn[PIN_SS]   = FN_SPI_OUT;
        gate[PIN_SS] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/spio_pin_mux.sv
module spio_pin_mux
  import spio_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst,
  input  pin_fn_e [PIN_N-1:0]   fn,
  input  logic    [PIN_N-1:0]   gate,
  input  logic    [PIN_N-1:0]   ddr,
  input  logic    [PIN_N-1:0]   port_out,
  input  logic    [PIN_N-1:0]   src,
  input  logic    [PIN_N-1:0]   pad_in,
  input  logic    [PIN_W-1:0]   sdi_sel,
  output logic    [PIN_N-1:0]   pad_out,
  output logic    [PIN_N-1:0]   pad_oe,
  output logic                  core_sdi,
  output logic                  core_sck_in,
  output logic                  core_ss_in
);
  logic [PIN_N-1:0] out_n;
  logic [PIN_N-1:0] oe_n;

  for (genvar i = 0; i < PIN_N; i++) begin : g_pin
    always_comb begin
      case (fn[i])
        FN_SPI_OUT, FN_SPI_IO: begin
          out_n[i] = src[i];
          oe_n[i]  = ddr[i] & gate[i];
        end
        FN_GPIO: begin
          out_n[i] = port_out[i];
          oe_n[i]  = ddr[i];
        end
        default: begin
          out_n[i] = 1'b0;
          oe_n[i]  = 1'b0;
        end
      endcase
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        pad_out[i] <= 1'b0;
        pad_oe[i]  <= 1'b0;
      end else begin
        pad_out[i] <= out_n[i];
        pad_oe[i]  <= oe_n[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      core_sdi    <= 1'b0;
      core_sck_in <= 1'b0;
      core_ss_in  <= 1'b1;
    end else begin
      core_sdi    <= pad_in[sdi_sel];
      core_sck_in <= pad_in[PIN_SCK];
      core_ss_in  <= pad_in[PIN_SS];
    end
  end
endmodule

// File: rtl/spio_clk_gate.sv
module spio_clk_gate (
  input  logic clk,
  input  logic rst,
  input  logic stop_wait,
  input  logic wait_mode,
  output logic clk_run
);
  always_ff @(posedge clk) begin
    if (rst) clk_run <= 1'b1;
    else     clk_run <= ~(stop_wait & wait_mode);
  end

  AST_CLK_HALT: assert property (@(posedge clk) disable iff (rst)
    (stop_wait && wait_mode) |=> !clk_run); // R11
  AST_CLK_FREE: assert property (@(posedge clk) disable iff (rst)
    !stop_wait |=> clk_run); // R11
endmodule

// File: rtl/spio_pin_ctrl.sv
module spio_pin_ctrl
  import spio_pkg::*;
#(
  parameter int REG_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reg_wr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  input  logic             mstr,
  input  logic             ssoe,
  input  logic [3:0]       ddr,
  input  logic [3:0]       port_out,
  input  logic             wait_mode,
  input  logic             core_sdo,
  input  logic             core_sck_out,
  input  logic             core_ss_out,
  input  logic [3:0]       pad_in,
  output logic [3:0]       pad_out,
  output logic [3:0]       pad_oe,
  output logic             core_sdi,
  output logic             core_sck_in,
  output logic             core_ss_in,
  output logic             clk_run
);
  ctl_t                ctl;
  pin_fn_e [PIN_N-1:0] fn;
  logic    [PIN_N-1:0] gate;
  logic    [PIN_W-1:0] sdi_sel;
  logic    [PIN_N-1:0] src;

  always_comb begin
    src           = '0;
    src[PIN_MISO] = core_sdo;
    src[PIN_MOSI] = core_sdo;
    src[PIN_SCK]  = core_sck_out;
    src[PIN_SS]   = core_ss_out;
  end

  spio_ctl_reg #(.REG_W(REG_W)) u_ctl (
    .clk(clk), .rst(rst), .wr(reg_wr), .wdata(reg_wdata),
    .ctl(ctl), .rdata(reg_rdata)
  );

  spio_role_dec u_dec (
    .one_wire(ctl.one_wire), .mstr(mstr), .ssoe(ssoe),
    .ss_pad(pad_in[PIN_SS]), .fn(fn), .gate(gate), .sdi_sel(sdi_sel)
  );

  spio_pin_mux u_mux (
    .clk(clk), .rst(rst), .fn(fn), .gate(gate), .ddr(ddr),
    .port_out(port_out), .src(src), .pad_in(pad_in), .sdi_sel(sdi_sel),
    .pad_out(pad_out), .pad_oe(pad_oe), .core_sdi(core_sdi),
    .core_sck_in(core_sck_in), .core_ss_in(core_ss_in)
  );

  spio_clk_gate u_clk (
    .clk(clk), .rst(rst), .stop_wait(ctl.stop_wait),
    .wait_mode(wait_mode), .clk_run(clk_run)
  );

  for (genvar i = 0; i < PIN_N; i++) begin : g_ddr_chk
    AST_DDR_LOW_QUIET: assert property (@(posedge clk) disable iff (rst)
      !ddr[i] |=> !pad_oe[i]); // R8
  end

  AST_SCK_SLAVE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !mstr |=> !pad_oe[PIN_SCK]); // R3
  AST_MISO_MASTER_4W: assert property (@(posedge clk) disable iff (rst)
    (mstr && !ctl.one_wire) |=> !pad_oe[PIN_MISO]); // R4
  AST_SLAVE_SS_HIGH: assert property (@(posedge clk) disable iff (rst)
    (!mstr && pad_in[PIN_SS]) |=> !pad_oe[PIN_MISO]); // R7
  AST_SS_DRIVE_GATE: assert property (@(posedge clk) disable iff (rst)
    !(mstr && ssoe && ddr[PIN_SS]) |=> !pad_oe[PIN_SS]); // R9
  AST_GPIO_MOSI: assert property (@(posedge clk) disable iff (rst)
    (ctl.one_wire && !mstr) |=> (pad_out[PIN_MOSI] == $past(port_out[PIN_MOSI]))); // R10
endmodule

// File: tb/sim_spio_pin_ctrl.sv
`timescale 1ns/1ps
module sim_spio_pin_ctrl;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       mstr = 1'b0, ssoe = 1'b0, wait_mode = 1'b0;
  logic [3:0] ddr = '0, port_out = '0, pad_in = 4'b1000;
  logic       core_sdo = 1'b0, core_sck_out = 1'b0, core_ss_out = 1'b0;
  logic [3:0] pad_out, pad_oe;
  logic       core_sdi, core_sck_in, core_ss_in, clk_run;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  logic [1:0] ctl_m = '0;

  always #5 clk = ~clk;

  spio_pin_ctrl u0 (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .mstr(mstr), .ssoe(ssoe), .ddr(ddr),
    .port_out(port_out), .wait_mode(wait_mode), .core_sdo(core_sdo),
    .core_sck_out(core_sck_out), .core_ss_out(core_ss_out), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .core_sdi(core_sdi),
    .core_sck_in(core_sck_in), .core_ss_in(core_ss_in), .clk_run(clk_run)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic void model(output logic [3:0] eo, output logic [3:0] eoe,
                                output logic esdi, output logic erun);
    logic ssl;
    eo = '0; eoe = '0;
    ssl = ~pad_in[3];
    case ({ctl_m[0], mstr})
      2'b00: begin eo[0] = core_sdo; eoe[0] = ddr[0] & ssl; esdi = pad_in[1]; end
      2'b01: begin eo[1] = core_sdo; eoe[1] = ddr[1]; esdi = pad_in[0]; end
      2'b10: begin eo[0] = core_sdo; eoe[0] = ddr[0] & ssl;
                   eo[1] = port_out[1]; eoe[1] = ddr[1]; esdi = pad_in[0]; end
      default: begin eo[1] = core_sdo; eoe[1] = ddr[1];
                   eo[0] = port_out[0]; eoe[0] = ddr[0]; esdi = pad_in[1]; end
    endcase
    if (mstr) begin
      eo[2] = core_sck_out; eoe[2] = ddr[2];
      if (ssoe) begin eo[3] = core_ss_out; eoe[3] = ddr[3]; end
    end
    erun = ~(ctl_m[1] & wait_mode);
  endfunction

  function automatic string mode_tag();
    case ({ctl_m[0], mstr})
      2'b00: return "R3";
      2'b01: return "R4";
      2'b10: return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic wr_ctl(input logic [7:0] d);
    reg_wr = 1'b1; reg_wdata = d;
    tick();
    reg_wr = 1'b0;
    ctl_m = d[1:0];
    tick();
  endtask

  task automatic check_all(input string tag);
    logic [3:0] eo, eoe; logic esdi, erun;
    model(eo, eoe, esdi, erun);
    check({tag, " pad_out"}, {4'b0, pad_out}, {4'b0, eo});
    check({tag, " pad_oe"}, {4'b0, pad_oe}, {4'b0, eoe});
    check({tag, " sdi"}, {7'b0, core_sdi}, {7'b0, esdi});
    check("R12 sck_in/ss_in", {6'b0, core_sck_in, core_ss_in}, {6'b0, pad_in[2], pad_in[3]});
    check("R11 clk_run", {7'b0, clk_run}, {7'b0, erun});
  endtask

  task automatic rnd_inputs();
    mstr = 1'($urandom); ssoe = 1'($urandom); wait_mode = 1'($urandom);
    ddr = 4'($urandom); port_out = 4'($urandom); pad_in = 4'($urandom);
    core_sdo = 1'($urandom); core_sck_out = 1'($urandom); core_ss_out = 1'($urandom);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  %0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [3:0] hold_o, hold_oe;
    void'($urandom(32'd4242));
    repeat (3) tick();
    rst = 1'b0;
    #1;
    // R1: reset state, sampled before any input changes
    check("R1 rdata", reg_rdata, 8'h00);
    check("R1 pad_oe", {4'b0, pad_oe}, 8'h00);
    check("R1 clk_run", {7'b0, clk_run}, 8'h01);

    // R2: register bits and reserved bits
    wr_ctl(8'hFF);
    check("R2 rdata ff", reg_rdata, 8'h03);
    wr_ctl(8'hA2);
    check("R2 rdata a2", reg_rdata, 8'h02);
    wr_ctl(8'h00);
    check("R2 rdata 00", reg_rdata, 8'h00);

    // R7: slave driver needs select low
    mstr = 0; ddr = 4'hF; pad_in = 4'b1000; core_sdo = 1;
    tick(); check("R7 ss high", {7'b0, pad_oe[0]}, 8'h00);
    pad_in = 4'b0000;
    tick(); check("R7 ss low", {7'b0, pad_oe[0]}, 8'h01);
    ddr = 4'hE;
    tick(); check("R7 ddr0 low", {7'b0, pad_oe[0]}, 8'h00);

    // R8: master drivers need direction bits
    mstr = 1; ssoe = 1; ddr = 4'h0;
    tick(); check("R8 ddr zero", {4'b0, pad_oe}, 8'h00);
    ddr = 4'h6;
    tick(); check("R8 mosi+sck", {4'b0, pad_oe}, 8'h06);

    // R9: select output gating
    ddr = 4'hF; ssoe = 0;
    tick(); check("R9 ssoe low", {7'b0, pad_oe[3]}, 8'h00);
    ssoe = 1; core_ss_out = 1;
    tick(); check("R9 ssoe high", {6'b0, pad_oe[3], pad_out[3]}, 8'h03);
    mstr = 0;
    tick(); check("R9 slave", {7'b0, pad_oe[3]}, 8'h00);

    // R10: released pads follow port_out
    wr_ctl(8'h01);
    mstr = 1; ddr = 4'h1; port_out = 4'b0001; core_sdo = 0;
    tick(); check("R10 miso gpio", {6'b0, pad_oe[0], pad_out[0]}, 8'h03);
    mstr = 0; ddr = 4'h2; port_out = 4'b0000; core_sdo = 1; pad_in = 4'b0000;
    tick(); check("R10 mosi gpio", {6'b0, pad_oe[1], pad_out[1]}, 8'h02);

    // R11: clock stop combinations
    wr_ctl(8'h02); wait_mode = 1;
    tick(); check("R11 halt", {7'b0, clk_run}, 8'h00);
    wait_mode = 0;
    tick(); check("R11 no wait", {7'b0, clk_run}, 8'h01);
    wr_ctl(8'h00); wait_mode = 1;
    tick(); check("R11 bit clear", {7'b0, clk_run}, 8'h01);

    // R12: outputs hold until the next edge
    mstr = 1; ddr = 4'hF; ssoe = 1; core_sdo = 1; core_sck_out = 1;
    tick();
    hold_o = pad_out; hold_oe = pad_oe;
    ddr = 4'h0; core_sdo = 0; #2;
    check("R12 hold", {hold_o, hold_oe}, {pad_out, pad_oe});
    tick(); check("R12 after edge", {4'b0, pad_oe}, 8'h00);
    mstr = 0; pad_in = 4'b0110;
    tick(); check("R12 input role zero", {5'b0, pad_out[3:1]}, 8'h00);

    // Random sweep in all four routing modes
    for (int n = 0; n < 400; n++) begin
      if ((n % 25) == 0) wr_ctl(8'($urandom));
      rnd_inputs();
      tick();
      check_all(mode_tag());
    end

    done = 1;
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule